// File: doc/BRIEF.md
# Pulse-Pair Line Decoder

This block sits behind a window-comparator receiver on a transformer-coupled two-wire link. Every clock it samples the receiver's tri-level decision. Each event on the link arrives as a symmetric pulse pair: one half at one polarity, then at once a half of the same width at the other polarity, so the pair carries no DC. The block measures the length of each half in clock cycles. It sorts the pair into one of three width classes and uses the polarity of the first half to tell events apart.

From each accepted pair it rebuilds the serial-bus lines of the far side. Long pairs move chip select. Medium pairs set the data-in level. Short pairs pull the master-side data-out line low for one bit time, and the line returns high when no further short pair arrives. Pairs that are malformed are dropped and flagged with an error pulse. Every accepted pair also raises a one-cycle strobe together with a 3-bit event code. Widths and tolerance are parameters in clock cycles. The defaults (2, 5 and 8 cycles, ±1) suit a 40 MHz sampling clock.

Top module: `pp_pair_decoder`

## Requirements
- R1: `sym_i` encodes the receiver decision: 2'b01 is positive, 2'b11 is negative, and 2'b00 or 2'b10 is idle. A stretch of idle alone never produces a strobe, an error or a line change.
- R2: A half belongs to a width class when its length in cycles is within `HALF_TOL` of that class's nominal (`SHORT_HALF`=2, `MID_HALF`=5, `LONG_HALF`=8 by default). A length that fits no window belongs to no class.
- R3: A long pair whose first half is negative drives `cs_o` low with code 1. A long pair whose first half is positive drives `cs_o` high with code 2.
- R4: A medium pair whose first half is positive sets `sdi_o` to 1 with code 3. A medium pair whose first half is negative sets `sdi_o` to 0 with code 4.
- R5: A short pair of either polarity drives `sdo_o` low with code 5. `sdo_o` stays low for exactly `SDO_HOLD` cycles after the strobe cycle and then returns to 1. Each further short pair restarts that count.
- R6: When a half fits no class, the pair is rejected. The block pulses `err_o` and changes no line. `err_o` and `evt_valid_o` are never high together.
- R7: A first half must be followed directly by the opposite polarity. If an idle sample comes first, or the line goes straight to idle, the block raises an error.
- R8: When the two halves fall into different classes, the block raises an error and changes no line.
- R9: During and after reset, `cs_o`, `sdi_o` and `sdo_o` are 1, and `evt_valid_o`, `err_o` and `evt_code_o` are 0.
- R10: The strobe, code and error appear one cycle after the first sample that ends the deciding half, and they last one cycle.
- R11: A pair may start on the very sample that ends the previous pair. Back-to-back pairs are each accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_i | input | 2 | Tri-level receiver decision (R1 encoding) |
| evt_valid_o | output | 1 | One-cycle strobe per accepted pair |
| evt_code_o | output | 3 | Event code of the accepted pair, 0 otherwise |
| err_o | output | 1 | One-cycle pulse per rejected pair |
| cs_o | output | 1 | Rebuilt chip select |
| sdi_o | output | 1 | Rebuilt slave data-in |
| sdo_o | output | 1 | Rebuilt master data-out |

## Verification
The hardest cases to reach are half lengths that sit just outside one window and inside the next. A short half of four cycles reads as medium, and a long half of six cycles reads as medium too, so whether a pair is accepted depends on how both halves land together. The bench drives every combination of both half lengths from nominal minus two to nominal plus two, for each class and polarity. This includes mixed-class pairs and halves that fit no window. The SDO restart case is reached by sending a second short pair while the first hold is still running, then timing the release from the second strobe.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam logic [1:0] SYM_IDLE = 2'b00;
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b11;

  typedef enum logic [1:0] {W_NONE, W_SHORT, W_MID, W_LONG} width_e;

  typedef enum logic [2:0] {
    EV_NONE     = 3'd0,
    EV_CS_FALL  = 3'd1,
    EV_CS_RISE  = 3'd2,
    EV_SDI_ONE  = 3'd3,
    EV_SDI_ZERO = 3'd4,
    EV_SDO_LOW  = 3'd5
  } evt_e;

  // idle for any code that is not a legal polarity
  function automatic logic [1:0] norm_sym(input logic [1:0] s);
    return (s == SYM_POS || s == SYM_NEG) ? s : SYM_IDLE;
  endfunction

  function automatic logic [1:0] opposite(input logic [1:0] s);
    return (s == SYM_POS) ? SYM_NEG : SYM_POS;
  endfunction

  // length within nominal +/- tol, done without negative numbers
  function automatic logic in_win(input int unsigned len, input int unsigned nom,
                                  input int unsigned tol);
    return (len + tol >= nom) && (len <= nom + tol);
  endfunction

  function automatic evt_e evt_of(input width_e cls, input logic neg_first);
    case (cls)
      W_LONG:  return neg_first ? EV_CS_FALL : EV_CS_RISE;
      W_MID:   return neg_first ? EV_SDI_ZERO : EV_SDI_ONE;
      W_SHORT: return EV_SDO_LOW;
      default: return EV_NONE;
    endcase
  endfunction
endpackage

// File: rtl/pp_run_meter.sv
module pp_run_meter #(
  parameter int CNT_MAX = 10,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       sym_i,
  output logic             run_end_o,
  output logic [1:0]       run_sym_o,
  output logic [CNT_W-1:0] run_len_o
);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(CNT_MAX);

  logic [1:0]       cur_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= pp_pkg::SYM_IDLE;
      cnt_q <= LIM;
    end else if (sym_i != cur_q) begin
      cur_q <= sym_i;
      cnt_q <= CNT_W'(1);
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // a run closes on the first sample of a different symbol
  assign run_end_o = (sym_i != cur_q);
  assign run_sym_o = cur_q;
  assign run_len_o = cnt_q;
endmodule

// File: rtl/pp_width_class.sv
module pp_width_class #(
  parameter int SHORT_HALF = 2,
  parameter int MID_HALF   = 5,
  parameter int LONG_HALF  = 8,
  parameter int HALF_TOL   = 1,
  parameter int CNT_W      = 4
) (
  input  logic [CNT_W-1:0] len_i,
  output pp_pkg::width_e   cls_o
);
  localparam int N_CLS = 3;
  localparam int NOMS [N_CLS] = '{SHORT_HALF, MID_HALF, LONG_HALF};

  logic [N_CLS-1:0] hit;

  for (genvar g = 0; g < N_CLS; g++) begin : g_win
    assign hit[g] = pp_pkg::in_win(32'(len_i), NOMS[g], HALF_TOL);
  end

  always_comb begin
    cls_o = pp_pkg::W_NONE;
    if (hit[0])      cls_o = pp_pkg::W_SHORT;
    else if (hit[1]) cls_o = pp_pkg::W_MID;
    else if (hit[2]) cls_o = pp_pkg::W_LONG;
  end
endmodule

// File: rtl/pp_pair_seq.sv
module pp_pair_seq (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_end_i,
  input  logic [1:0]     run_sym_i,
  input  pp_pkg::width_e run_cls_i,
  input  logic [1:0]     next_sym_i,
  output logic           pair_ok_o,
  output logic           pair_bad_o,
  output pp_pkg::evt_e   evt_o
);
  import pp_pkg::*;

  logic   have_first_q;
  logic   first_neg_q;
  width_e first_cls_q;
  logic   first_good;

  // a first half is kept only if it fits a class and flips straight over
  assign first_good = (run_sym_i != SYM_IDLE) && (run_cls_i != W_NONE) &&
                      (next_sym_i == opposite(run_sym_i));

  always_comb begin
    pair_ok_o  = 1'b0;
    pair_bad_o = 1'b0;
    evt_o      = EV_NONE;
    if (run_end_i) begin
      if (have_first_q) begin
        if (run_cls_i == first_cls_q) begin
          pair_ok_o = 1'b1;
          evt_o     = evt_of(first_cls_q, first_neg_q);
        end else begin
          pair_bad_o = 1'b1;
        end
      end else if (run_sym_i != SYM_IDLE && !first_good) begin
        pair_bad_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_first_q <= 1'b0;
      first_neg_q  <= 1'b0;
      first_cls_q  <= W_NONE;
    end else if (run_end_i) begin
      if (have_first_q) begin
        have_first_q <= 1'b0;
      end else if (first_good) begin
        have_first_q <= 1'b1;
        first_neg_q  <= (run_sym_i == SYM_NEG);
        first_cls_q  <= run_cls_i;
      end
    end
  end
endmodule

// File: rtl/pp_line_rebuild.sv
module pp_line_rebuild #(
  parameter int SDO_HOLD = 40,
  localparam int TMR_W = $clog2(SDO_HOLD + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pair_ok_i,
  input  logic         pair_bad_i,
  input  pp_pkg::evt_e evt_i,
  output logic         evt_valid_o,
  output pp_pkg::evt_e evt_code_o,
  output logic         err_o,
  output logic         cs_o,
  output logic         sdi_o,
  output logic         sdo_o
);
  import pp_pkg::*;

  logic [TMR_W-1:0] tmr_q;
  evt_e             acc;

  assign acc = pair_ok_i ? evt_i : EV_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_valid_o <= 1'b0;
      evt_code_o  <= EV_NONE;
      err_o       <= 1'b0;
      cs_o        <= 1'b1;
      sdi_o       <= 1'b1;
    end else begin
      evt_valid_o <= pair_ok_i;
      evt_code_o  <= acc;
      err_o       <= pair_bad_i;
      case (acc)
        EV_CS_FALL:  cs_o  <= 1'b0;
        EV_CS_RISE:  cs_o  <= 1'b1;
        EV_SDI_ONE:  sdi_o <= 1'b1;
        EV_SDI_ZERO: sdi_o <= 1'b0;
        default: ;
      endcase
    end
  end

  // data-out line: low for SDO_HOLD cycles after each short pair
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdo_o <= 1'b1;
      tmr_q <= '0;
    end else if (acc == EV_SDO_LOW) begin
      sdo_o <= 1'b0;
      tmr_q <= TMR_W'(SDO_HOLD);
    end else if (tmr_q > TMR_W'(1)) begin
      tmr_q <= tmr_q - TMR_W'(1);
    end else if (tmr_q == TMR_W'(1)) begin
      tmr_q <= '0;
      sdo_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pp_pair_decoder.sv
module pp_pair_decoder #(
  parameter int SHORT_HALF = 2,
  parameter int MID_HALF   = 5,
  parameter int LONG_HALF  = 8,
  parameter int HALF_TOL   = 1,
  parameter int SDO_HOLD   = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sym_i,
  output logic       evt_valid_o,
  output logic [2:0] evt_code_o,
  output logic       err_o,
  output logic       cs_o,
  output logic       sdi_o,
  output logic       sdo_o
);
  localparam int CNT_MAX = LONG_HALF + HALF_TOL + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [1:0]       sym_n;
  logic             run_end;
  logic [1:0]       run_sym;
  logic [CNT_W-1:0] run_len;
  pp_pkg::width_e   run_cls;
  logic             pair_ok;
  logic             pair_bad;
  pp_pkg::evt_e     pair_evt;
  pp_pkg::evt_e     code_q;

  assign sym_n = pp_pkg::norm_sym(sym_i);

  pp_run_meter #(.CNT_MAX(CNT_MAX)) u_meter (
    .clk(clk), .rst_n(rst_n), .sym_i(sym_n),
    .run_end_o(run_end), .run_sym_o(run_sym), .run_len_o(run_len)
  );

  pp_width_class #(
    .SHORT_HALF(SHORT_HALF), .MID_HALF(MID_HALF), .LONG_HALF(LONG_HALF),
    .HALF_TOL(HALF_TOL), .CNT_W(CNT_W)
  ) u_class (
    .len_i(run_len), .cls_o(run_cls)
  );

  pp_pair_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run_end_i(run_end), .run_sym_i(run_sym),
    .run_cls_i(run_cls), .next_sym_i(sym_n),
    .pair_ok_o(pair_ok), .pair_bad_o(pair_bad), .evt_o(pair_evt)
  );

  pp_line_rebuild #(.SDO_HOLD(SDO_HOLD)) u_lines (
    .clk(clk), .rst_n(rst_n), .pair_ok_i(pair_ok), .pair_bad_i(pair_bad),
    .evt_i(pair_evt), .evt_valid_o(evt_valid_o), .evt_code_o(code_q),
    .err_o(err_o), .cs_o(cs_o), .sdi_o(sdi_o), .sdo_o(sdo_o)
  );

  assign evt_code_o = code_q;
endmodule

// File: rtl/pp_pair_decoder_chk.sv
module pp_pair_decoder_chk #(
  parameter int SDO_HOLD = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       run_end,
  input logic       pair_ok,
  input logic [2:0] pair_code,
  input logic       evt_valid_o,
  input logic       err_o,
  input logic       cs_o,
  input logic       sdi_o,
  input logic       sdo_o
);
  localparam int LC_W = $clog2(SDO_HOLD + 2) + 1;

  logic            short_acc;
  logic [LC_W-1:0] low_cnt;

  assign short_acc = pair_ok && (pair_code == 3'd5);

  always_ff @(posedge clk) begin
    if (!rst_n)                low_cnt <= '0;
    else if (short_acc)        low_cnt <= LC_W'(1);
    else if (sdo_o)            low_cnt <= '0;
    else                       low_cnt <= low_cnt + LC_W'(1);
  end

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_valid_o && err_o));

  p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid_o || err_o) |-> $past(run_end));

  p_cs_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cs_o) |-> ($past(pair_ok) && ($past(pair_code) == 3'd1 || $past(pair_code) == 3'd2)));

  p_sdi_move_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdi_o) |-> ($past(pair_ok) && ($past(pair_code) == 3'd3 || $past(pair_code) == 3'd4)));

  p_sdo_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdo_o) |-> $past(short_acc));

  p_sdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_o) |-> ($past(low_cnt) == LC_W'(SDO_HOLD)));
endmodule

bind pp_pair_decoder pp_pair_decoder_chk #(.SDO_HOLD(SDO_HOLD)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_end(run_end), .pair_ok(pair_ok),
  .pair_code(pair_evt), .evt_valid_o(evt_valid_o), .err_o(err_o),
  .cs_o(cs_o), .sdi_o(sdi_o), .sdo_o(sdo_o)
);

// File: tb/tb_pp_pair_decoder.sv
module tb_pp_pair_decoder;
  localparam int HOLD = 40;
  localparam logic [1:0] IDL = 2'b00;
  localparam logic [1:0] POS = 2'b01;
  localparam logic [1:0] NEG = 2'b11;
  localparam logic [1:0] BAD = 2'b10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sym = IDL;
  logic       evt_valid_o, err_o, cs_o, sdi_o, sdo_o;
  logic [2:0] evt_code_o;

  int n_chk = 0;
  int n_fail = 0;
  int exp_cs = 1;
  int exp_sdi = 1;

  always #10 clk = ~clk;

  pp_pair_decoder #(.SDO_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .sym_i(sym), .evt_valid_o(evt_valid_o),
    .evt_code_o(evt_code_o), .err_o(err_o), .cs_o(cs_o), .sdi_o(sdi_o), .sdo_o(sdo_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic [1:0] s, input int n);
    sym = s;
    repeat (n) @(negedge clk);
  endtask

  // class index from length: 1 short, 2 medium, 3 long, 0 none
  function automatic int bcls(input int len);
    int noms [3] = '{2, 5, 8};
    for (int k = 0; k < 3; k++) begin
      int d = (len > noms[k]) ? len - noms[k] : noms[k] - len;
      if (d <= 1) return k + 1;
    end
    return 0;
  endfunction

  function automatic int bcode(input int c, input bit neg);
    if (c == 3) return neg ? 1 : 2;
    if (c == 2) return neg ? 4 : 3;
    if (c == 1) return 5;
    return 0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: state while reset is held
    chk("R9 cs", cs_o, 1); chk("R9 sdi", sdi_o, 1); chk("R9 sdo", sdo_o, 1);
    chk("R9 valid", evt_valid_o, 0); chk("R9 err", err_o, 0); chk("R9 code", evt_code_o, 0);
    rst_n = 1'b1;
    hold(IDL, 3);

    // R1: illegal code 10 is idle, alone it does nothing
    hold(BAD, 8); hold(IDL, 1);
    chk("R1 valid", evt_valid_o, 0); chk("R1 err", err_o, 0);
    hold(IDL, 3);
    chk("R1 cs", cs_o, 1); chk("R1 err later", err_o, 0);

    // R2 R3 R4 R5 R6 R8 R10: sweep both half lengths per class and polarity
    for (int k = 1; k <= 3; k++) begin
      for (int pn = 0; pn < 2; pn++) begin
        for (int l1 = 0; l1 < 5; l1++) begin
          for (int l2 = 0; l2 < 5; l2++) begin
            int nom = (k == 1) ? 2 : (k == 2) ? 5 : 8;
            int a = nom - 2 + l1;
            int b = nom - 2 + l2;
            int c1, c2, code;
            bit ok;
            if (a < 1 || b < 1) continue;
            c1 = bcls(a); c2 = bcls(b);
            ok = (c1 != 0) && (c1 == c2);
            code = ok ? bcode(c1, pn == 1) : 0;
            hold(pn == 1 ? NEG : POS, a);
            hold(pn == 1 ? POS : NEG, b);
            hold(IDL, 1);
            if (ok && code == 1) exp_cs = 0;
            if (ok && code == 2) exp_cs = 1;
            if (ok && code == 3) exp_sdi = 1;
            if (ok && code == 4) exp_sdi = 0;
            chk("R2 R6 R8 valid", evt_valid_o, int'(ok));
            chk("R6 R8 err", err_o, int'(!ok));
            chk("R3 R4 R5 code", evt_code_o, code);
            chk("R3 cs", cs_o, exp_cs);
            chk("R4 sdi", sdi_o, exp_sdi);
            chk("R5 sdo", sdo_o, (ok && code == 5) ? 0 : 1);
            hold(IDL, 1);
            chk("R10 one-cycle strobe", evt_valid_o, 0);
            chk("R10 one-cycle err", err_o, 0);
            hold(IDL, HOLD + 2);
          end
        end
      end
    end

    // R7: idle gap between halves
    hold(POS, 5); hold(IDL, 1);
    chk("R7 gap err", err_o, 1);
    hold(NEG, 5); hold(IDL, 1);
    chk("R7 gap no strobe", evt_valid_o, 0);
    chk("R7 sdi kept", sdi_o, exp_sdi);
    hold(IDL, 3);
    // R7: code 10 acts as a gap
    hold(NEG, 8); hold(BAD, 1);
    chk("R7 code10 err", err_o, 1);
    hold(POS, 8); hold(IDL, 1);
    chk("R7 code10 cs kept", cs_o, exp_cs);
    hold(IDL, 3);

    // R11: back-to-back pairs, medium then short
    hold(NEG, 5); hold(POS, 5); hold(NEG, 1);
    chk("R11 first strobe", evt_valid_o, 1);
    chk("R11 first code", evt_code_o, 4);
    chk("R11 sdi", sdi_o, 0);
    hold(NEG, 1); hold(POS, 2); hold(IDL, 1);
    chk("R11 second strobe", evt_valid_o, 1);
    chk("R11 second code", evt_code_o, 5);
    hold(IDL, HOLD + 2);
    chk("R5 released", sdo_o, 1);

    // R5: exact hold and restart by a second short pair
    hold(POS, 2); hold(NEG, 2); hold(IDL, 1);
    chk("R5 low", sdo_o, 0);
    hold(IDL, 30);
    chk("R5 still low", sdo_o, 0);
    hold(NEG, 2); hold(POS, 2); hold(IDL, 1);
    chk("R5 reload strobe", evt_code_o, 5);
    hold(IDL, HOLD - 1);
    chk("R5 low to last cycle", sdo_o, 0);
    hold(IDL, 1);
    chk("R5 high after hold", sdo_o, 1);

    // R3: chip select back high after a long positive pair
    hold(POS, 8); hold(NEG, 8); hold(IDL, 1);
    chk("R3 rise code", evt_code_o, 2);
    chk("R3 cs high", cs_o, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule